// File: doc/BRIEF.md
# Six-Read Unlock Sequence Detector

This block sits beside a static RAM and watches its bus for a fixed run of six read accesses. The run unlocks a nonvolatile command: the first five addresses form a fixed prefix, and the sixth decides whether the block raises a one-clock store request, a one-clock recall request, or nothing. An access is counted only when chip enable goes from inactive to active between two clock samples. The address is taken in that cycle. Any write, or any read of an address that is not expected, drops the partial sequence.

A controller that runs the nonvolatile cycle reports busy on `hold`. While `hold` is high the detector stays idle and ignores the bus. The `step_idx` output shows how many prefix addresses have been matched so far, which helps when debugging.

Top module: `nv_unlock_seq`

## Requirements
- R1: Read accesses to 14-bit addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order, move `step_idx` through 1, 2, 3, 4 and 5. `step_idx` is 0 when idle and after reset.
- R2: When `step_idx` is 5, a read of 0x0FC0 drives `store_req` high for the one clock that follows the sampling edge, and `step_idx` returns to 0.
- R3: When `step_idx` is 5, a read of 0x0C63 drives `recall_req` high for the one clock that follows the sampling edge, and `step_idx` returns to 0.
- R4: Only address bits 13..0 are compared. Bit 14 has no effect on matching.
- R5: A clock edge that sees `ce_n` low and `we_n` low is a write. It sends `step_idx` to 0 and raises no request. This holds whether the write is a fresh access or `we_n` falls during an access that is already under way.
- R6: A read whose address is not the expected one aborts the sequence to `step_idx` 0. If that read is to 0x0E38, it is instead taken as step 1 and `step_idx` becomes 1.
- R7: An access is counted only at a clock edge where `ce_n` is low and was high at the previous edge. Address changes while `ce_n` stays low are not counted.
- R8: Any sixth access returns the detector to idle. A sixth access to the reserved code 0x339C, or to any other non-command address, raises no request.
- R9: Each request lasts exactly one clock, and `store_req` and `recall_req` are never high together.
- R10: While `hold` is high, `step_idx` is forced to 0 in the next cycle, no request is raised, and accesses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 15 | Memory address bus |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| hold | input | 1 | Controller busy; keeps the detector idle |
| store_req | output | 1 | One-clock store request |
| recall_req | output | 1 | One-clock recall request |
| step_idx | output | 3 | Number of prefix addresses matched |

## Verification
Complete store and recall sequences are run with bit 14 both clear and set, so that command decode can be told apart from a full-width compare. The bench then sweeps every step position, inserting four kinds of disruption at each one: a wrong address, a restart address, a fresh write, and a write that begins partway through an access. After each disruption it completes the sequence, which distinguishes an abort from a restart and shows where the counter resumes. Further cases cover the reserved sixth code, a wrong sixth address, an address change while chip enable stays low, and accesses made under `hold`. Together these show that only falling chip-enable edges are counted and that busy fully gates the detector.

// File: rtl/nv_unlock_pkg.sv
package nv_unlock_pkg;
  localparam int CMP_W     = 14;
  localparam int PREFIX_N  = 5;
  localparam int STEP_W    = $clog2(PREFIX_N + 1);

  localparam logic [CMP_W-1:0] CODE_STORE  = 14'h0FC0;
  localparam logic [CMP_W-1:0] CODE_RECALL = 14'h0C63;
  localparam logic [CMP_W-1:0] CODE_TEST   = 14'h339C;

  typedef enum logic [1:0] {CMD_NONE, CMD_STORE, CMD_RECALL, CMD_TEST} cmd_e;

  function automatic logic [CMP_W-1:0] prefix_key(input int idx);
    case (idx)
      0: prefix_key = 14'h0E38;
      1: prefix_key = 14'h31C7;
      2: prefix_key = 14'h03E0;
      3: prefix_key = 14'h3C1F;
      default: prefix_key = 14'h303F;
    endcase
  endfunction

  function automatic cmd_e decode_cmd(input logic [CMP_W-1:0] a);
    if (a == CODE_STORE)       decode_cmd = CMD_STORE;
    else if (a == CODE_RECALL) decode_cmd = CMD_RECALL;
    else if (a == CODE_TEST)   decode_cmd = CMD_TEST;
    else                       decode_cmd = CMD_NONE;
  endfunction
endpackage

// File: rtl/nv_access_sampler.sv
module nv_access_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic hold,
  output logic acc_read,
  output logic wr_now
);
  logic ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_n;
  end

  logic ce_fall;
  assign ce_fall  = ce_q & ~ce_n;
  assign wr_now   = ~ce_n & ~we_n;
  assign acc_read = ce_fall & we_n & ~hold;
endmodule

// File: rtl/nv_key_match.sv
module nv_key_match
  import nv_unlock_pkg::*;
(
  input  logic [CMP_W-1:0]  addr_cmp,
  input  logic [STEP_W-1:0] step,
  output logic              step_hit,
  output logic              head_hit,
  output cmd_e              cmd
);
  logic [PREFIX_N-1:0] hit;

  for (genvar g = 0; g < PREFIX_N; g++) begin : g_key
    assign hit[g] = (addr_cmp == prefix_key(g));
  end

  assign head_hit = hit[0];

  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < PREFIX_N; i++) begin
      if (step == STEP_W'(i)) step_hit = hit[i];
    end
  end

  assign cmd = decode_cmd(addr_cmp);
endmodule

// File: rtl/nv_seq_fsm.sv
module nv_seq_fsm
  import nv_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              acc_read,
  input  logic              wr_now,
  input  logic              step_hit,
  input  logic              head_hit,
  input  cmd_e              cmd,
  output logic [STEP_W-1:0] step,
  output logic              store_q,
  output logic              recall_q
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_N);

  logic [STEP_W-1:0] step_d;
  logic              store_d, recall_d;
  logic              final_acc;

  assign final_acc = acc_read & (step == LAST);

  always_comb begin
    step_d   = step;
    store_d  = 1'b0;
    recall_d = 1'b0;
    if (hold || wr_now) begin
      step_d = '0;
    end else if (acc_read) begin
      if (final_acc) begin
        step_d   = '0;
        store_d  = (cmd == CMD_STORE);
        recall_d = (cmd == CMD_RECALL);
      end else if (step_hit) begin
        step_d = step + 1'b1;
      end else if (head_hit) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      step     <= step_d;
      store_q  <= store_d;
      recall_q <= recall_d;
    end
  end
endmodule

// File: rtl/nv_unlock_seq.sv
module nv_unlock_seq
  import nv_unlock_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              hold,
  output logic              store_req,
  output logic              recall_req,
  output logic [STEP_W-1:0] step_idx
);
  logic [CMP_W-1:0] addr_cmp;
  logic             acc_read, wr_now, step_hit, head_hit;
  cmd_e             cmd;

  assign addr_cmp = addr[CMP_W-1:0];

  // Upper address bits above the compare window are deliberately left out.
  if (ADDR_W > CMP_W) begin : g_upper
    logic unused_upper;
    assign unused_upper = ^addr[ADDR_W-1:CMP_W];
  end

  nv_access_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .hold(hold),
    .acc_read(acc_read), .wr_now(wr_now)
  );

  nv_key_match u_match (
    .addr_cmp(addr_cmp), .step(step_idx),
    .step_hit(step_hit), .head_hit(head_hit), .cmd(cmd)
  );

  nv_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold(hold), .acc_read(acc_read),
    .wr_now(wr_now), .step_hit(step_hit), .head_hit(head_hit), .cmd(cmd),
    .step(step_idx), .store_q(store_req), .recall_q(recall_req)
  );
endmodule

// File: rtl/nv_unlock_seq_chk.sv
module nv_unlock_seq_chk
  import nv_unlock_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              acc_read,
  input logic              wr_now,
  input logic              store_req,
  input logic              recall_req,
  input logic [STEP_W-1:0] step_idx
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));

  a_r9_store_single: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);

  a_r9_recall_single: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (step_idx == '0) && !store_req && !recall_req);

  a_r5_write_abort: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> (step_idx == '0) && !store_req && !recall_req);

  a_r2_store_from_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_req) |-> $past(step_idx) == STEP_W'(PREFIX_N));

  a_r3_recall_from_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_req) |-> $past(step_idx) == STEP_W'(PREFIX_N));

  a_r1_step_moves_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_read && !wr_now && !hold) |=> $stable(step_idx));

  a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx <= STEP_W'(PREFIX_N));
endmodule

bind nv_unlock_seq nv_unlock_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .acc_read(acc_read),
  .wr_now(wr_now), .store_req(store_req), .recall_req(recall_req),
  .step_idx(step_idx)
);

// File: tb/nv_unlock_seq_tb.sv
module nv_unlock_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic        hold = 1'b0;
  logic        store_req, recall_req;
  logic [2:0]  step_idx;

  int tests = 0;
  int fails = 0;
  int exp_step = 0;
  bit exp_st = 0, exp_rc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nv_unlock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
    .hold(hold), .store_req(store_req), .recall_req(recall_req),
    .step_idx(step_idx)
  );

  logic [13:0] keys [6];
  initial begin
    keys[0] = 14'h0E38; keys[1] = 14'h31C7; keys[2] = 14'h03E0;
    keys[3] = 14'h3C1F; keys[4] = 14'h303F; keys[5] = 14'h0FC0;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    chk({req, " step"}, step_idx, exp_step);
    chk({req, " store"}, store_req, exp_st);
    chk({req, " recall"}, recall_req, exp_rc);
  endtask

  // reference model of one counted access
  task automatic model(input logic [14:0] a, input bit wr);
    logic [13:0] k;
    k = a[13:0];
    exp_st = 0; exp_rc = 0;
    if (hold || wr) exp_step = 0;
    else if (exp_step == 5) begin
      exp_st = (k == 14'h0FC0);
      exp_rc = (k == 14'h0C63);
      exp_step = 0;
    end else if (k == keys[exp_step]) exp_step++;
    else if (k == keys[0]) exp_step = 1;
    else exp_step = 0;
  endtask

  // one access: ce_n low for one clock, then high for one clock
  task automatic acc(input logic [14:0] a, input bit wr, input string req);
    @(negedge clk);
    addr = a; we_n = ~wr; ce_n = 1'b0;
    @(negedge clk);
    model(a, wr);
    check_outs(req);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    exp_st = 0; exp_rc = 0;
    chk({req, " pulse one clock R9"}, {30'd0, store_req, recall_req}, 0);
  endtask

  task automatic run_prefix(input logic [14:0] upper, input string req);
    for (int i = 0; i < 5; i++) acc(upper | {1'b0, keys[i]}, 0, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outs("reset R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: store sequence
    run_prefix(15'h0000, "R1 prefix");
    acc(15'h0FC0, 0, "R2 store");
    // R3: recall sequence
    run_prefix(15'h0000, "R1 prefix");
    acc(15'h0C63, 0, "R3 recall");
    // R4: bit 14 set throughout
    run_prefix(15'h4000, "R4 upper bit");
    acc(15'h4FC0, 0, "R4 store upper bit");
    run_prefix(15'h4000, "R4 upper bit");
    acc(15'h4C63, 0, "R4 recall upper bit");
    // R8: reserved code and wrong sixth
    run_prefix(15'h0000, "R8 prefix");
    acc(15'h339C, 0, "R8 reserved sixth");
    run_prefix(15'h0000, "R8 prefix");
    acc(15'h0E38, 0, "R8 wrong sixth idle");

    // sweep disruption at every step position, then finish with store
    for (int p = 0; p <= 5; p++) begin
      for (int kind = 0; kind < 4; kind++) begin
        for (int i = 0; i < p; i++) acc({1'b0, keys[i]}, 0, "R1 sweep prefix");
        case (kind)
          0: acc({1'b0, keys[p] ^ 14'h0001}, 0, "R6 wrong address abort");
          1: acc(15'h0E38, 0, "R6 restart on head");
          2: acc({1'b0, keys[p]}, 1, "R5 write access abort");
          default: begin
            @(negedge clk);
            addr = {1'b0, keys[p]}; ce_n = 1'b0;
            @(negedge clk);
            model(addr, 0);
            check_outs("R5 read before mid write");
            exp_st = 0; exp_rc = 0;
            we_n = 1'b0;
            @(negedge clk);
            exp_step = 0;
            check_outs("R5 mid access write");
            ce_n = 1'b1; we_n = 1'b1;
            @(negedge clk);
          end
        endcase
        for (int i = exp_step; i < 5; i++) acc({1'b0, keys[i]}, 0, "R6 resume");
        acc(15'h0FC0, 0, "R2 store after sweep");
      end
    end

    // R7: ce held low while address walks ahead
    @(negedge clk);
    addr = 15'h0E38; ce_n = 1'b0;
    @(negedge clk);
    model(addr, 0);
    check_outs("R7 first access");
    for (int i = 1; i < 5; i++) begin
      addr = {1'b0, keys[i]};
      @(negedge clk);
      check_outs("R7 no count while ce low");
    end
    ce_n = 1'b1;
    @(negedge clk);
    acc(15'h31C7, 0, "R7 counted after release");

    // R10: hold clears and ignores
    @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    exp_step = 0; exp_st = 0; exp_rc = 0;
    check_outs("R10 hold clears");
    run_prefix(15'h0000, "R10 ignored under hold");
    acc(15'h0FC0, 0, "R10 no store under hold");
    hold = 1'b0;
    run_prefix(15'h0000, "R10 after hold");
    acc(15'h0C63, 0, "R10 recall after hold");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule